// File: doc/BRIEF.md
# Smart-card T=0 character transmitter

This block sends bytes to a smart card over a single shared, open-drain I/O line using the character-level T=0 protocol. A byte is taken through a valid/ready handshake. The block then sends a low start bit, the eight data bits least significant first, and an even parity bit. Each bit lasts `etu_cycles` clock cycles, which is the elementary time unit (ETU) derived from the card's Fi/Di ratio.

After the parity bit the block stops driving the line. It looks for a card error signal in the first guard ETU. If the card pulls the line low at that point, the block flags a parity error and waits out the NACK ETU and two guard ETUs. It then repeats the same byte. It does this until the repetition limit is used up, at which point it abandons the byte and reports it. If the card stays silent, the byte completes after two guard ETUs.

The line is only ever pulled low. A high level is produced by releasing the line, and an external pull-up holds it high.

Top module: `sc_t0_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `tx_ready` is 1, `line_drive_low` is 0 and `nack_pulse`, `char_done` and `give_up` are 0. While a character is in progress, including its repetitions, `tx_ready` is 0.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. The start bit begins in the following cycle. Bits occupy consecutive ETUs of `etu_cycles` cycles each, in this order:
  - slot 0 carries the start bit, which is 0;
  - slots 1 to 8 carry data bits 0 to 7;
  - slot 9 carries the parity bit.
- R3: The parity bit is the XOR of the eight data bits, so the nine bits together hold an even number of ones.
- R4: `line_drive_low` is 1 only during slots 0 to 9 and only for bits of value 0. It is 0 during all guard and NACK ETUs.
- R5: The line is sampled once per attempt, at cycle floor(`etu_cycles`/2) of slot 10, the first guard ETU. If `line_sense` is 0 there, `nack_pulse` is 1 for exactly that cycle.
- R6: On an attempt without NACK, `char_done` pulses in the last cycle of slot 11, which is 12·E−1 cycles after the first start-bit cycle (E = `etu_cycles`). `tx_ready` is 1 in the next cycle.
- R7: After a NACK with repetitions left, the same byte is restarted with its start bit exactly 14·E cycles after the previous start bit.
- R8: At most `max_repeat` repetitions follow the first attempt. When attempt number `max_repeat`+1 is also refused, `give_up` pulses in the last cycle of slot 13 (14·E−1 cycles after its start). No further repetition follows, and `tx_ready` returns to 1.
- R9: `tx_valid` and `tx_data` have no effect while `tx_ready` is 0. No extra character is sent, and the character in flight keeps its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; all timing counts its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte to send |
| tx_ready | output | 1 | Block idle, byte accepted on this edge if valid |
| etu_cycles | input | ETU_W | Clock cycles per ETU (0 is treated as 1) |
| max_repeat | input | REP_W | Repetitions allowed after a refused first attempt |
| line_sense | input | 1 | Level seen on the shared I/O line |
| line_drive_low | output | 1 | 1 pulls the I/O line low, 0 releases it |
| nack_pulse | output | 1 | One-cycle parity-error flag: card signalled NACK |
| char_done | output | 1 | One-cycle pulse: byte delivered without NACK |
| give_up | output | 1 | One-cycle pulse: byte abandoned after the last repetition |

## Verification
A wrong slot count or a slipped ETU counter shows on the line within one bit time: a data bit, the parity bit or the start bit lands at the wrong mid-ETU sample. A lost NACK state shows as `char_done` twelve ETUs after the start instead of a restart fourteen ETUs after it. A wrong repetition count shows as one restart too many or too few before `give_up`, so the error appears at most one character later. A sequencer that is not idle, or that takes a stray byte, shows at once as a dropped `tx_ready` or as a frame that the scoreboard does not expect.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

  localparam logic [3:0] SLOT_PARITY    = 4'd9;
  localparam logic [3:0] SLOT_GUARD1    = 4'd10;
  localparam logic [3:0] SLOT_LAST_OK   = 4'd11;
  localparam logic [3:0] SLOT_LAST_NACK = 4'd13;

  // even parity: the XOR of all eight data bits
  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

  // level carried in a given bit slot; guard slots are released (1)
  function automatic logic slot_level(input logic [7:0] d, input logic [3:0] slot);
    logic lvl;
    case (slot)
      4'd0:    lvl = 1'b0;
      4'd1:    lvl = d[0];
      4'd2:    lvl = d[1];
      4'd3:    lvl = d[2];
      4'd4:    lvl = d[3];
      4'd5:    lvl = d[4];
      4'd6:    lvl = d[5];
      4'd7:    lvl = d[6];
      4'd8:    lvl = d[7];
      4'd9:    lvl = even_par(d);
      default: lvl = 1'b1;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/sc_t0_etu_timer.sv
module sc_t0_etu_timer #(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ETU_W-1:0] etu_cycles,
  output logic             etu_end,
  output logic             etu_mid
);
  logic [ETU_W-1:0] cnt_q;
  logic [ETU_W-1:0] etu_len;
  logic [ETU_W-1:0] etu_last;

  assign etu_len  = (etu_cycles == '0) ? ETU_W'(1) : etu_cycles;
  assign etu_last = etu_len - ETU_W'(1);
  assign etu_end  = run && (cnt_q == etu_last);
  assign etu_mid  = run && (cnt_q == (etu_len >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || etu_end)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + ETU_W'(1);
  end
endmodule

// File: rtl/sc_t0_frame_seq.sv
module sc_t0_frame_seq
  import sc_t0_pkg::*;
#(
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [7:0]       data_in,
  input  logic             etu_end,
  input  logic             etu_mid,
  input  logic             line_sense,
  input  logic [REP_W-1:0] max_repeat,
  output logic             busy,
  output logic [3:0]       slot,
  output logic [7:0]       data_q,
  output logic             nack_pulse,
  output logic             char_done,
  output logic             give_up
);
  logic             busy_q;
  logic             nack_q;
  logic [3:0]       slot_q;
  logic [REP_W-1:0] rep_q;
  logic [3:0]       last_slot;
  logic             frame_end;
  logic             retry;

  assign last_slot  = nack_q ? SLOT_LAST_NACK : SLOT_LAST_OK;
  assign nack_pulse = busy_q && (slot_q == SLOT_GUARD1) && etu_mid && !line_sense;
  assign frame_end  = busy_q && etu_end && (slot_q == last_slot);
  assign char_done  = frame_end && !nack_q;
  assign retry      = frame_end && nack_q && (rep_q < max_repeat);
  assign give_up    = frame_end && nack_q && !(rep_q < max_repeat);

  assign busy = busy_q;
  assign slot = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      nack_q <= 1'b0;
      slot_q <= '0;
      rep_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      nack_q <= 1'b0;
      slot_q <= '0;
      rep_q  <= '0;
      data_q <= data_in;
    end else if (busy_q) begin
      if (nack_pulse) nack_q <= 1'b1;
      if (etu_end) begin
        if (frame_end) begin
          slot_q <= '0;
          nack_q <= 1'b0;
          if (retry) rep_q  <= rep_q + REP_W'(1);
          else       busy_q <= 1'b0;
        end else begin
          slot_q <= slot_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
  import sc_t0_pkg::*;
#(
  parameter int ETU_W = 12,
  parameter int REP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [ETU_W-1:0] etu_cycles,
  input  logic [REP_W-1:0] max_repeat,
  input  logic             line_sense,
  output logic             line_drive_low,
  output logic             nack_pulse,
  output logic             char_done,
  output logic             give_up
);
  logic       busy_w;
  logic [3:0] slot_w;
  logic [7:0] data_w;
  logic       etu_end_w;
  logic       etu_mid_w;
  logic       accept_w;

  assign tx_ready = !busy_w;
  assign accept_w = tx_valid && !busy_w;

  sc_t0_etu_timer #(.ETU_W(ETU_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy_w),
    .etu_cycles (etu_cycles),
    .etu_end    (etu_end_w),
    .etu_mid    (etu_mid_w)
  );

  sc_t0_frame_seq #(.REP_W(REP_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept_w),
    .data_in    (tx_data),
    .etu_end    (etu_end_w),
    .etu_mid    (etu_mid_w),
    .line_sense (line_sense),
    .max_repeat (max_repeat),
    .busy       (busy_w),
    .slot       (slot_w),
    .data_q     (data_w),
    .nack_pulse (nack_pulse),
    .char_done  (char_done),
    .give_up    (give_up)
  );

  // open-drain stage: pull low only for a 0 bit inside slots 0..9
  assign line_drive_low = busy_w && (slot_w <= SLOT_PARITY) && !slot_level(data_w, slot_w);
endmodule

module sc_t0_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       line_drive_low,
  input logic       line_sense,
  input logic       nack_pulse,
  input logic       char_done,
  input logic       give_up,
  input logic       busy,
  input logic [3:0] slot
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!line_drive_low && !nack_pulse && !char_done && !give_up));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> line_drive_low);

  a_r4_guard_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot >= 4'd10) |-> !line_drive_low);

  a_r5_nack_in_guard1: assert property (@(posedge clk) disable iff (!rst_n)
    nack_pulse |-> (slot == 4'd10 && !line_sense));

  a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nack_pulse, char_done, give_up}));

  a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> tx_ready);

  a_r8_ready_after_giveup: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> tx_ready);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !char_done && !give_up) |=> !tx_ready);
endmodule

bind sc_t0_tx sc_t0_tx_chk chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .line_drive_low (line_drive_low),
  .line_sense     (line_sense),
  .nack_pulse     (nack_pulse),
  .char_done      (char_done),
  .give_up        (give_up),
  .busy           (busy_w),
  .slot           (slot_w)
);

// File: tb/sc_t0_tx_tb.sv
module sc_t0_tx_tb_top;
  typedef struct {
    logic [7:0] d;
    int         nacks;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [11:0] etu = 12'd8;
  logic [2:0]  max_rep = 3'd3;
  logic        card_pull = 1'b0;
  logic        line_sense;
  logic        line_drive_low;
  logic        nack_pulse, char_done, give_up;

  int nchecks = 0, nerr = 0, cyc = 0;
  int seen_done = 0, seen_give = 0, seen_nack = 0;
  int exp_done = 0, exp_give = 0, exp_nack = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign line_sense = !(line_drive_low || card_pull);

  sc_t0_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .etu_cycles(etu), .max_repeat(max_rep),
    .line_sense(line_sense), .line_drive_low(line_drive_low),
    .nack_pulse(nack_pulse), .char_done(char_done), .give_up(give_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int ones(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) n += d[i];
    return n;
  endfunction

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // driver: record the expected outcome, then hand the byte over
  task automatic send(input logic [7:0] d, input int nacks);
    item_t it;
    bit hs;
    it.d = d;
    it.nacks = nacks;
    exp_q.push_back(it);
    if (nacks > int'(max_rep)) begin
      exp_give++;
      exp_nack += int'(max_rep) + 1;
    end else begin
      exp_done++;
      exp_nack += nacks;
    end
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    forever begin
      hs = tx_ready;
      @(negedge clk);
      if (hs) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    seen_done += char_done;
    seen_give += give_up;
    seen_nack += nack_pulse;
  end

  // monitor / card model: decodes frames, injects NACKs, checks timing
  initial begin
    int attempts = 0;
    int restart_at = -1;
    forever begin
      @(negedge clk);
      if (rst_n && !line_sense && !card_pull) begin
        int k, e;
        item_t cur;
        logic [7:0] got;
        logic par;
        bit nack;
        k = cyc;
        e = int'(etu);
        if (restart_at >= 0) chk(k == restart_at, "R7 restart cycle", k, restart_at);
        restart_at = -1;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected frame", 1, 0);
          wait_to(k + 12 * e);
          continue;
        end
        cur = exp_q[0];
        chk(tx_ready == 1'b0, "R1 busy not ready", tx_ready, 0);
        wait_to(k + e / 2);
        chk(line_sense == 1'b0, "R2 start bit", line_sense, 0);
        for (int i = 0; i < 8; i++) begin
          wait_to(k + (i + 1) * e + e / 2);
          got[i] = line_sense;
        end
        chk(got == cur.d, "R2 data bits", got, cur.d);
        wait_to(k + 9 * e + e / 2);
        par = line_sense;
        chk(((ones(cur.d) + par) % 2) == 0, "R3 even parity", par, ones(cur.d) % 2);
        nack = (attempts < cur.nacks);
        wait_to(k + 10 * e);
        card_pull = nack;
        wait_to(k + 10 * e + e / 2);
        chk(nack_pulse == nack, "R5 nack sample", nack_pulse, nack);
        chk(line_drive_low == 1'b0, "R4 guard1 released", line_drive_low, 0);
        wait_to(k + 11 * e);
        card_pull = 1'b0;
        wait_to(k + 11 * e + e / 2);
        chk(line_drive_low == 1'b0, "R4 guard2 released", line_drive_low, 0);
        if (!nack) begin
          wait_to(k + 12 * e - 1);
          chk(char_done == 1'b1, "R6 char_done", char_done, 1);
          wait_to(k + 12 * e);
          chk(tx_ready == 1'b1, "R6 ready after done", tx_ready, 1);
          void'(exp_q.pop_front());
          attempts = 0;
        end else begin
          attempts++;
          wait_to(k + 14 * e - 1);
          if (attempts > int'(max_rep)) begin
            chk(give_up == 1'b1, "R8 give_up", give_up, 1);
            wait_to(k + 14 * e);
            chk(tx_ready == 1'b1, "R8 ready after give_up", tx_ready, 1);
            chk(line_drive_low == 1'b0, "R8 no further repeat", line_drive_low, 0);
            void'(exp_q.pop_front());
            attempts = 0;
          end else begin
            chk(give_up == 1'b0 && char_done == 1'b0, "R7 no end pulse", give_up, 0);
            restart_at = k + 14 * e;
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);
    chk(line_drive_low == 1'b0, "R1 line released", line_drive_low, 0);
    chk(!nack_pulse && !char_done && !give_up, "R1 no pulses", 0, 0);

    // plain bytes back to back, E = 8
    send(8'hA5, 0);
    send(8'h3C, 0);
    send(8'h00, 0);
    send(8'hFF, 0);
    drain();

    // two refusals then success
    send(8'h5A, 2);
    drain();

    // odd ETU, limit exhausted, then a clean byte
    etu = 12'd5;
    send(8'h81, 4);
    send(8'h7E, 0);
    drain();

    // no repetitions allowed
    etu = 12'd6;
    max_rep = 3'd0;
    send(8'hC3, 1);
    send(8'h11, 0);
    drain();

    // R9: stray requests while busy are ignored
    max_rep = 3'd2;
    send(8'h96, 0);
    tx_valid = 1'b1;
    tx_data  = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_ready == 1'b0, "R9 ready low while busy", tx_ready, 0);
    end
    tx_valid = 1'b0;
    drain();
    repeat (20 * 6) @(negedge clk);
    chk(tx_ready == 1'b1 && line_drive_low == 1'b0, "R9 no stray frame", line_drive_low, 0);

    chk(seen_done == exp_done, "R6 char_done count", seen_done, exp_done);
    chk(seen_give == exp_give, "R8 give_up count", seen_give, exp_give);
    chk(seen_nack == exp_nack, "R5 nack count", seen_nack, exp_nack);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule